// File: doc/BRIEF.md
# Voice Interrupt Acknowledge Arbiter

This block collects interrupt requests raised by up to 32 synthesizer voices. Each voice can raise two kinds of request: a wave-end event and a volume-ramp event. Every request sets a bit in a pending vector for its class, and the arbiter then hands pending requests to the host one at a time. The block keeps two class summary flags and an interrupt line.

The host acknowledges a request by writing the function-select value 0x8F. On that write the arbiter looks for a pending source among voices 0 to 30, lowest index first. A wave-end request always wins over a volume-ramp request. The arbiter clears the chosen pending bit and sends a one-cycle clear pulse to bit 7 of the matching voice control register. It also latches a status byte that names the class and the voice. If nothing in the scan window is pending, it latches an idle code.

Writing 0 to bit 0 of the run-control register empties both vectors at once. All pins are plain control or status pins. There is no data stream and no valid/ready handshake, so no back-pressure applies: every request pulse and every host write is taken in the cycle it is presented.

Top module: `voice_irq_arbiter`

## Requirements
- R1: After reset, `status_byte` is 0xE8, both class flags and `irq` are 0, and both clear-pulse vectors are 0.
- R2: A request pulse on `wave_req[v]` or `ramp_req[v]` makes the pending bit for that class and voice set at the next clock edge. The class flag (`wave_flag` or `ramp_flag`) and `irq` then read 1.
- R3: Only a `fsel_wr` strobe carrying `fsel_data` = 0x8F is an acknowledge. A write of any other value changes no output.
- R4: On an acknowledge with wave-end requests pending among voices 0..30, the lowest such voice v is served. `status_byte` becomes {3'b011, v[4:0]}, that is 0x60 | v.
- R5: On an acknowledge, any pending wave-end request in voices 0..30 is served before any volume-ramp request.
- R6: On an acknowledge with no wave-end request in 0..30 but volume-ramp requests pending there, the lowest such voice v is served. `status_byte` becomes {3'b100, v[4:0]}, that is 0x80 | v.
- R7: On an acknowledge with nothing pending among voices 0..30, `status_byte` becomes 0xE8.
- R8: Voice 31 is never served. A pending request on voice 31 keeps its class flag and `irq` set.
- R9: Serving a request clears its pending bit. For exactly one cycle, bit v of `wave_ctl_clr` or `ramp_ctl_clr` (matching the class) is 1. At most one clear-pulse bit is 1 in any cycle.
- R10: A class flag reads 0 exactly when its pending vector is empty. `irq` is 1 exactly while either flag is 1.
- R11: A new request that arrives in the same cycle that its own bit is acknowledged stays pending.
- R12: A `run_wr` strobe with `run_keep` = 0 empties both vectors, drops both flags and `irq`, and cancels any acknowledge or request presented in that cycle. `status_byte` keeps its value. With `run_keep` = 1 the strobe has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wave_req | input | 32 | Per-voice wave-end request pulses |
| ramp_req | input | 32 | Per-voice volume-ramp request pulses |
| fsel_wr | input | 1 | Host write strobe to the function-select register |
| fsel_data | input | 8 | Value written to the function-select register |
| run_wr | input | 1 | Host write strobe to the run-control register |
| run_keep | input | 1 | Bit 0 of the run-control write; 0 empties all pending state |
| status_byte | output | 8 | Latched acknowledge status byte |
| wave_ctl_clr | output | 32 | One-cycle pulse clearing bit 7 of a voice wave control register |
| ramp_ctl_clr | output | 32 | One-cycle pulse clearing bit 7 of a voice ramp control register |
| wave_flag | output | 1 | Global status: wave-end requests pending |
| ramp_flag | output | 1 | Global status: volume-ramp requests pending |
| irq | output | 1 | Interrupt request line |

## Verification
The embedded assertions check these properties on every cycle:
- The clear pulses are never more than one-hot.
- A request that is not cancelled is always pending one cycle later.
- A wave-end acknowledge never emits a ramp clear and carries the wave tag.
- An acknowledge with an empty window yields the idle code.
- The line drops after a run-control clear.

Only the bench's scenarios can show the following:
- That the lowest index is chosen.
- That voice 31 is skipped while still holding the interrupt.
- That a served flag drops only once its whole vector empties.
- That other function-select values are ignored.

// File: rtl/voice_irq_pkg.sv
package voice_irq_pkg;
  localparam logic [7:0] ACK_CODE      = 8'h8F;
  localparam logic [7:0] IDLE_CODE     = 8'hE8;
  localparam int         VOICE_FIELD_W = 5;
  localparam logic [2:0] WAVE_TAG      = 3'b011;
  localparam logic [2:0] RAMP_TAG      = 3'b100;
endpackage

// File: rtl/voice_irq_pending.sv
module voice_irq_pending #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_all,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] ack_i,
  output logic [W-1:0] pend_o,
  output logic         any_o
);
  logic [W-1:0] pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pend_q <= '0;
    else if (clear_all) pend_q <= '0;
    else                pend_q <= (pend_q & ~ack_i) | set_i;
  end

  assign pend_o = pend_q;
  assign any_o  = |pend_q;

  // R11: a request that is not cancelled is visible on the next cycle
  assert_req_sticks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_all && set_i != '0) |=> ((pend_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/voice_irq_pick.sv
module voice_irq_pick #(
  parameter int W     = 32,
  parameter int LIMIT = 31,
  parameter int IW    = 5
) (
  input  logic [W-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o,
  output logic [W-1:0]  onehot_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = LIMIT - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = i[IW-1:0];
      end
    end
    onehot_o = found_o ? (ONE << idx_o) : '0;
  end

  always_comb begin
    if (found_o) assert_pick_in_vec_R4: assert ((vec_i & onehot_o) == onehot_o);
  end
endmodule

// File: rtl/voice_irq_arbiter.sv
module voice_irq_arbiter #(
  parameter int NUM_VOICES = 32,
  parameter int SCAN_LIMIT = 31
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_VOICES-1:0] wave_req,
  input  logic [NUM_VOICES-1:0] ramp_req,
  input  logic                  fsel_wr,
  input  logic [7:0]            fsel_data,
  input  logic                  run_wr,
  input  logic                  run_keep,
  output logic [7:0]            status_byte,
  output logic [NUM_VOICES-1:0] wave_ctl_clr,
  output logic [NUM_VOICES-1:0] ramp_ctl_clr,
  output logic                  wave_flag,
  output logic                  ramp_flag,
  output logic                  irq
);
  import voice_irq_pkg::*;

  localparam int IW = $clog2(NUM_VOICES);

  logic                  ack, clear_all, serve_wave, serve_ramp;
  logic                  w_found, r_found;
  logic [IW-1:0]         w_idx, r_idx;
  logic [NUM_VOICES-1:0] w_onehot, r_onehot, w_ack_vec, r_ack_vec;
  logic [NUM_VOICES-1:0] w_pend, r_pend;

  assign ack        = fsel_wr && (fsel_data == ACK_CODE);
  assign clear_all  = run_wr && !run_keep;
  assign serve_wave = ack && w_found;
  assign serve_ramp = ack && !w_found && r_found;
  assign w_ack_vec  = serve_wave ? w_onehot : '0;
  assign r_ack_vec  = serve_ramp ? r_onehot : '0;

  voice_irq_pending #(.W(NUM_VOICES)) u_wave_pend (
    .clk(clk), .rst_n(rst_n), .clear_all(clear_all),
    .set_i(wave_req), .ack_i(w_ack_vec), .pend_o(w_pend), .any_o(wave_flag));

  voice_irq_pending #(.W(NUM_VOICES)) u_ramp_pend (
    .clk(clk), .rst_n(rst_n), .clear_all(clear_all),
    .set_i(ramp_req), .ack_i(r_ack_vec), .pend_o(r_pend), .any_o(ramp_flag));

  voice_irq_pick #(.W(NUM_VOICES), .LIMIT(SCAN_LIMIT), .IW(IW)) u_wave_pick (
    .vec_i(w_pend), .found_o(w_found), .idx_o(w_idx), .onehot_o(w_onehot));

  voice_irq_pick #(.W(NUM_VOICES), .LIMIT(SCAN_LIMIT), .IW(IW)) u_ramp_pick (
    .vec_i(r_pend), .found_o(r_found), .idx_o(r_idx), .onehot_o(r_onehot));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_byte  <= IDLE_CODE;
      wave_ctl_clr <= '0;
      ramp_ctl_clr <= '0;
    end else if (clear_all) begin
      wave_ctl_clr <= '0;
      ramp_ctl_clr <= '0;
    end else begin
      wave_ctl_clr <= w_ack_vec;
      ramp_ctl_clr <= r_ack_vec;
      if (serve_wave)      status_byte <= {WAVE_TAG, VOICE_FIELD_W'(w_idx)};
      else if (serve_ramp) status_byte <= {RAMP_TAG, VOICE_FIELD_W'(r_idx)};
      else if (ack)        status_byte <= IDLE_CODE;
    end
  end

  assign irq = wave_flag | ramp_flag;

  // R9: at most one control-register clear pulse at a time
  assert_onehot_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wave_ctl_clr, ramp_ctl_clr}));

  // R5: a wave-end acknowledge never touches the ramp class
  assert_wave_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !clear_all && (w_pend[SCAN_LIMIT-1:0] != '0))
      |=> (ramp_ctl_clr == '0 && status_byte[7:5] == WAVE_TAG));

  // R7: empty scan window yields the idle code
  assert_idle_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !clear_all && (w_pend[SCAN_LIMIT-1:0] == '0) && (r_pend[SCAN_LIMIT-1:0] == '0))
      |=> (status_byte == IDLE_CODE));

  // R12: run-control clear drops the line
  assert_clear_drops_R12: assert property (@(posedge clk) disable iff (!rst_n)
    clear_all |=> (!irq && !wave_flag && !ramp_flag));
endmodule

// File: tb/test_voice_irq_arbiter.sv
module test_voice_irq_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] wave_req = '0, ramp_req = '0;
  logic        fsel_wr = 1'b0;
  logic [7:0]  fsel_data = '0;
  logic        run_wr = 1'b0, run_keep = 1'b1;
  logic [7:0]  status_byte;
  logic [31:0] wave_ctl_clr, ramp_ctl_clr;
  logic        wave_flag, ramp_flag, irq;

  int checks = 0, failures = 0;
  logic [31:0] m_wp = '0, m_rp = '0, m_wclr = '0, m_rclr = '0;
  logic [7:0]  m_st = 8'hE8;

  always #10 clk = ~clk;

  voice_irq_arbiter i_voice_irq_arbiter (
    .clk(clk), .rst_n(rst_n), .wave_req(wave_req), .ramp_req(ramp_req),
    .fsel_wr(fsel_wr), .fsel_data(fsel_data), .run_wr(run_wr), .run_keep(run_keep),
    .status_byte(status_byte), .wave_ctl_clr(wave_ctl_clr), .ramp_ctl_clr(ramp_ctl_clr),
    .wave_flag(wave_flag), .ramp_flag(ramp_flag), .irq(irq));

  function automatic int lowest(logic [31:0] v);
    for (int i = 0; i < 31; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk({tag, " status"}, 32'(status_byte), 32'(m_st));
    chk({tag, " wave_clr"}, wave_ctl_clr, m_wclr);
    chk({tag, " ramp_clr"}, ramp_ctl_clr, m_rclr);
    chk({tag, " wave_flag"}, 32'(wave_flag), 32'(|m_wp));
    chk({tag, " ramp_flag"}, 32'(ramp_flag), 32'(|m_rp));
    chk({tag, " irq"}, 32'(irq), 32'(|m_wp || |m_rp));
  endtask

  // Called at a negative edge; drives one cycle and checks after it.
  task automatic step(string tag, logic [31:0] wr, logic [31:0] rr,
                      logic fw, logic [7:0] fd, logic rw, logic rk);
    int w, r;
    wave_req = wr; ramp_req = rr; fsel_wr = fw; fsel_data = fd;
    run_wr = rw; run_keep = rk;
    @(posedge clk);
    m_wclr = '0; m_rclr = '0;
    if (rw && !rk) begin
      m_wp = '0; m_rp = '0;
    end else begin
      if (fw && fd == 8'h8F) begin
        w = lowest(m_wp); r = lowest(m_rp);
        if (w >= 0) begin m_st = 8'h60 | 8'(w); m_wclr[w] = 1'b1; end
        else if (r >= 0) begin m_st = 8'h80 | 8'(r); m_rclr[r] = 1'b1; end
        else m_st = 8'hE8;
      end
      m_wp = (m_wp & ~m_wclr) | wr;
      m_rp = (m_rp & ~m_rclr) | rr;
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(string tag);
    step(tag, '0, '0, 1'b0, 8'h00, 1'b0, 1'b1);
  endtask

  task automatic ackw(string tag);
    step(tag, '0, '0, 1'b1, 8'h8F, 1'b0, 1'b1);
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] rw_, rr_;
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after reset");

    step("R2 requests", 32'h0000_0024, 32'h0000_0001, 1'b0, 8'h00, 1'b0, 1'b1);
    step("R3 other fsel value", '0, '0, 1'b1, 8'h8E, 1'b0, 1'b1);
    step("R3 ramp code value", '0, '0, 1'b1, 8'h0F, 1'b0, 1'b1);
    ackw("R4 lowest wave R9");
    idle("R9 pulse ends");
    ackw("R4 next wave R10");
    ackw("R6 ramp served R10");
    ackw("R7 idle code");
    step("R8 voice31 request", 32'h8000_0000, 32'h8000_0000, 1'b0, 8'h00, 1'b0, 1'b1);
    ackw("R8 voice31 skipped");
    step("R5 mixed requests", 32'h0000_0080, 32'h0000_0008, 1'b0, 8'h00, 1'b0, 1'b1);
    ackw("R5 wave before ramp");
    ackw("R6 ramp after wave");
    step("R11 setup", 32'h0000_0008, '0, 1'b0, 8'h00, 1'b0, 1'b1);
    step("R11 same cycle", 32'h0000_0008, '0, 1'b1, 8'h8F, 1'b0, 1'b1);
    ackw("R11 served again");
    step("R12 keep write", 32'h0000_0300, 32'h0000_0300, 1'b0, 8'h00, 1'b1, 1'b1);
    step("R12 clear write", 32'h0000_0001, '0, 1'b1, 8'h8F, 1'b1, 1'b0);
    ackw("R12 empty after clear R7");

    for (int n = 0; n < 600; n++) begin
      rw_ = $urandom & $urandom & $urandom;
      rr_ = $urandom & $urandom & $urandom;
      if ($urandom_range(0, 2) != 0) begin rw_ = '0; rr_ = '0; end
      step("R5 random",
           rw_, rr_, ($urandom_range(0, 2) != 0),
           ($urandom_range(0, 5) == 0) ? 8'($urandom) : 8'h8F,
           ($urandom_range(0, 40) == 0), 1'($urandom));
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule